// File: doc/BRIEF.md
# Delayed Read Request Queue with Head Timeout

This block keeps the delayed read requests that one direction of a bridge has taken on but not yet completed. Each incoming read, an address plus a command code, is compared against every live entry. A read that matches an entry on both fields is flagged as a duplicate and is not stored. A new read is stored when a slot is free. When the queue is full, the read is refused so that the initiator retries it. Entries leave in arrival order.

The oldest entry owns a timeout counter. The counter is loaded from a programmed value each time an entry becomes the oldest. It counts down only in cycles where the target has the completion ready and that completion's data is the oldest in the read data queue. The entry retires when the initiator repeats the read. If the counter runs out first, the block drops the entry, pulses a discard output and, if reporting is enabled, pulses an error output. Data storage and ordering against posted writes live elsewhere.

The timer is a three-state machine. TM_IDLE means the queue is empty. TM_FRESH means the counter has been loaded and has not yet counted. TM_COUNT means it has counted at least once. The transitions are: load (to TM_FRESH, when a new entry becomes the oldest); tick (TM_FRESH or TM_COUNT to TM_COUNT, on a gated cycle); hold (stay in the same state on a non-gated cycle); clear (to TM_IDLE, when the last entry leaves).

Top module: `dlyrd_queue`

## Requirements
- R1: A read that matches no live entry and arrives while fewer than DEPTH (4) entries are live is stored. `rsp_accept` pulses for exactly the one cycle after the request cycle.
- R2: A read whose address and command both equal those of a live entry pulses `rsp_dup` in the following cycle and is not stored. The queue occupancy does not change.
- R3: A read that matches a live entry on only one of the two fields is not a duplicate.
- R4: Capacity is DEPTH entries. A non-duplicate read that arrives while the queue is full pulses `rsp_reject`. A duplicate arriving while the queue is full still pulses `rsp_dup`. At most one of the three response pulses is high in any cycle.
- R5: A `repeat_hit` pulse while the queue is non-empty retires the oldest entry, in FIFO order. The freed slot can take a new read in the very next cycle.
- R6: The timeout counter decrements only in cycles where `cpl_ready` and `rdq_head` are both high. Otherwise it holds its value for any length of time.
- R7: With a programmed value N (N ≥ 1), the oldest entry is removed at the N-th gated clock edge after it became oldest. `discard` pulses in the cycle after that edge, and the remaining entries stay queued.
- R8: `err_report` pulses together with `discard` exactly when `err_en` is high at expiry, and never at any other time.
- R9: Whenever a new entry becomes the oldest, including after an expiry or a retirement, its counter starts from the full programmed value.
- R10: A programmed value of 0 selects the default timeout of 32768 gated cycles.
- R11: If `repeat_hit` arrives in the same cycle the counter would expire, the retirement takes precedence and no `discard` is produced. A `repeat_hit` while the queue is empty has no effect.
- R12: After reset the queue is empty and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A new delayed read is presented this cycle |
| req_addr | input | AW (32) | Address of the read |
| req_cmd | input | CW (4) | Read command code |
| cpl_ready | input | 1 | The target side holds the completion for the oldest entry |
| rdq_head | input | 1 | The oldest entry's data is the oldest in the read data queue |
| repeat_hit | input | 1 | The initiator repeated the oldest read; retire it |
| tmo_value | input | TW (16) | Counter start value; 0 selects 32768 |
| err_en | input | 1 | Enables error reporting on expiry |
| rsp_accept | output | 1 | Pulse: the previous cycle's read was stored |
| rsp_dup | output | 1 | Pulse: the previous cycle's read was a duplicate |
| rsp_reject | output | 1 | Pulse: the previous cycle's read was refused because the queue was full |
| discard | output | 1 | Pulse: the oldest entry timed out and was dropped |
| err_report | output | 1 | Pulse: an expiry with reporting enabled |

## Verification
Every cycle, the assertions check that the response pulses are mutually exclusive and that an error pulse never appears without a discard. They also check that the counter holds whenever its gate is off and that the storage never overflows or underflows. Only the bench scenarios can show the cycle count to expiry, the reload for each new oldest entry, and the precedence of a repeat over an expiry. The same holds for FIFO retirement order and for a freed slot being reusable at once. The bench observes these at the ports, by timing the discard pulse and by re-sending reads to see whether they come back as duplicates.

// File: rtl/dlyrd_pkg.sv
package dlyrd_pkg;
    typedef enum logic [1:0] {
        TM_IDLE  = 2'd0,
        TM_FRESH = 2'd1,
        TM_COUNT = 2'd2
    } tmr_state_e;

    typedef enum logic [1:0] {
        RSP_NONE   = 2'd0,
        RSP_ACCEPT = 2'd1,
        RSP_DUP    = 2'd2,
        RSP_REJECT = 2'd3
    } rsp_e;
endpackage

// File: rtl/dlyrd_store.sv
module dlyrd_store #(
    parameter int DEPTH = 4,
    parameter int EW    = 36,
    localparam int PW   = $clog2(DEPTH),
    localparam int OW   = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                push,
    input  logic [EW-1:0]       push_data,
    input  logic                pop,
    output logic [DEPTH*EW-1:0] ent_flat,
    output logic [DEPTH-1:0]    ent_vld,
    output logic [OW-1:0]       occ,
    output logic                full,
    output logic                empty
);
    logic [EW-1:0] slot_q [DEPTH];
    logic [PW-1:0] wptr_q, rptr_q;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push) slot_q[wptr_q] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q  <= '0;
            rptr_q  <= '0;
            ent_vld <= '0;
            occ     <= '0;
        end else begin
            if (push) begin
                ent_vld[wptr_q] <= 1'b1;
                wptr_q          <= bump(wptr_q);
            end
            if (pop) begin
                ent_vld[rptr_q] <= 1'b0;
                rptr_q          <= bump(rptr_q);
            end
            occ <= occ + OW'(push) - OW'(pop);
        end
    end

    assign full  = (occ == OW'(DEPTH));
    assign empty = (occ == '0);

    for (genvar i = 0; i < DEPTH; i++) begin : g_flat
        assign ent_flat[i*EW +: EW] = slot_q[i];
    end

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (occ != OW'(DEPTH)));
    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (occ != '0));
endmodule

// File: rtl/dlyrd_match.sv
module dlyrd_match #(
    parameter int DEPTH = 4,
    parameter int EW    = 36
) (
    input  logic [DEPTH*EW-1:0] ent_flat,
    input  logic [DEPTH-1:0]    ent_vld,
    input  logic [EW-1:0]       key,
    output logic                hit
);
    logic [DEPTH-1:0] slot_hit;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign slot_hit[i] = ent_vld[i] && (ent_flat[i*EW +: EW] == key);
    end

    assign hit = |slot_hit;
endmodule

// File: rtl/dlyrd_timer.sv
module dlyrd_timer
    import dlyrd_pkg::*;
#(
    parameter int TW       = 16,
    parameter int TMO_DFLT = 32768
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          clear,
    input  logic          run,
    input  logic          hit_pop,
    input  logic [TW-1:0] tmo_value,
    output logic          expire
);
    tmr_state_e    state_q, state_d;
    logic [TW-1:0] cnt_q, cnt_d;
    logic [TW-1:0] start_val;

    assign start_val = (tmo_value == '0) ? TW'(TMO_DFLT) : tmo_value;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TM_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (load) begin
            state_d = TM_FRESH;
            cnt_d   = start_val;
        end else if (clear) begin
            state_d = TM_IDLE;
        end else begin
            unique case (state_q)
                TM_IDLE: ;
                TM_FRESH, TM_COUNT: begin
                    if (run) begin
                        state_d = TM_COUNT;
                        if (cnt_q != '0) cnt_d = cnt_q - TW'(1);
                    end
                end
                default: state_d = TM_IDLE;
            endcase
        end
    end

    always_comb begin
        expire = 1'b0;
        unique case (state_q)
            TM_FRESH, TM_COUNT: expire = run && !hit_pop && (cnt_q <= TW'(1));
            default:            expire = 1'b0;
        endcase
    end

    assert_hold_gate_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != TM_IDLE && !run && !load && !clear) |=> $stable(cnt_q));
endmodule

// File: rtl/dlyrd_queue.sv
module dlyrd_queue
    import dlyrd_pkg::*;
#(
    parameter int AW       = 32,
    parameter int CW       = 4,
    parameter int DEPTH    = 4,
    parameter int TW       = 16,
    parameter int TMO_DFLT = 32768
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic [CW-1:0] req_cmd,
    input  logic          cpl_ready,
    input  logic          rdq_head,
    input  logic          repeat_hit,
    input  logic [TW-1:0] tmo_value,
    input  logic          err_en,
    output logic          rsp_accept,
    output logic          rsp_dup,
    output logic          rsp_reject,
    output logic          discard,
    output logic          err_report
);
    localparam int EW = AW + CW;
    localparam int OW = $clog2(DEPTH + 1);

    logic [DEPTH*EW-1:0] ent_flat;
    logic [DEPTH-1:0]    ent_vld;
    logic [OW-1:0]       occ, occ_next;
    logic                full, empty, hit;
    logic                push, pop, rep_pop, gate, expire, load, clear;
    logic [EW-1:0]       key;
    rsp_e                rsp_d;

    assign key = {req_cmd, req_addr};

    dlyrd_match #(.DEPTH(DEPTH), .EW(EW)) u_match (
        .ent_flat (ent_flat),
        .ent_vld  (ent_vld),
        .key      (key),
        .hit      (hit)
    );

    assign push     = req_valid && !hit && !full;
    assign rep_pop  = repeat_hit && !empty;
    assign gate     = cpl_ready && rdq_head && !empty;
    assign pop      = rep_pop || expire;
    assign occ_next = occ + OW'(push) - OW'(pop);
    assign load     = (push && empty) || (pop && occ_next != '0);
    assign clear    = pop && (occ_next == '0);

    dlyrd_store #(.DEPTH(DEPTH), .EW(EW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (key),
        .pop       (pop),
        .ent_flat  (ent_flat),
        .ent_vld   (ent_vld),
        .occ       (occ),
        .full      (full),
        .empty     (empty)
    );

    dlyrd_timer #(.TW(TW), .TMO_DFLT(TMO_DFLT)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .clear     (clear),
        .run       (gate),
        .hit_pop   (rep_pop),
        .tmo_value (tmo_value),
        .expire    (expire)
    );

    always_comb begin
        rsp_d = RSP_NONE;
        if (req_valid) begin
            if (hit)       rsp_d = RSP_DUP;
            else if (full) rsp_d = RSP_REJECT;
            else           rsp_d = RSP_ACCEPT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_accept <= 1'b0;
            rsp_dup    <= 1'b0;
            rsp_reject <= 1'b0;
            discard    <= 1'b0;
            err_report <= 1'b0;
        end else begin
            rsp_accept <= (rsp_d == RSP_ACCEPT);
            rsp_dup    <= (rsp_d == RSP_DUP);
            rsp_reject <= (rsp_d == RSP_REJECT);
            discard    <= expire;
            err_report <= expire && err_en;
        end
    end

    assert_resp_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_accept, rsp_dup, rsp_reject}));
    assert_err_needs_discard_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_report |-> discard);
    assert_dup_needs_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_dup |-> ($past(occ) != '0));
    assert_dup_keeps_occ_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && hit && !pop) |=> $stable(occ));
endmodule

// File: tb/dlyrd_queue_test.sv
module dlyrd_queue_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [3:0]  req_cmd = '0;
    logic        cpl_ready = 1'b0;
    logic        rdq_head = 1'b0;
    logic        repeat_hit = 1'b0;
    logic [15:0] tmo_value = 16'd5;
    logic        err_en = 1'b0;
    logic        rsp_accept, rsp_dup, rsp_reject, discard, err_report;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    localparam int ACC = 1, DUP = 2, REJ = 3;

    dlyrd_queue uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_cmd(req_cmd), .cpl_ready(cpl_ready), .rdq_head(rdq_head),
        .repeat_hit(repeat_hit), .tmo_value(tmo_value), .err_en(err_en),
        .rsp_accept(rsp_accept), .rsp_dup(rsp_dup), .rsp_reject(rsp_reject),
        .discard(discard), .err_report(err_report)
    );

    always #5 clk = ~clk;

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run hung, actual %0d cycles, expected fewer", cycles);
            finish_run();
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // drive at a falling edge, return the response seen one cycle later
    task automatic send(input logic [31:0] a, input logic [3:0] c, output int r);
        req_valid = 1'b1; req_addr = a; req_cmd = c;
        @(negedge clk);
        req_valid = 1'b0;
        r = rsp_accept ? ACC : rsp_dup ? DUP : rsp_reject ? REJ : 0;
        if (int'(rsp_accept) + int'(rsp_dup) + int'(rsp_reject) > 1) r = 9;
    endtask

    task automatic retire();
        repeat_hit = 1'b1;
        @(negedge clk);
        repeat_hit = 1'b0;
    endtask

    task automatic wait_discard(input int maxc, output int k, output bit e);
        k = 0; e = 1'b0;
        while (k < maxc) begin
            @(negedge clk);
            k++;
            if (discard) begin e = err_report; break; end
        end
    endtask

    initial begin
        int r, k;
        bit e;
        repeat (3) @(negedge clk);
        // R12: reset state
        check(!rsp_accept && !rsp_dup && !rsp_reject && !discard && !err_report,
              "R12 outputs low in reset", 1, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!rsp_accept && !rsp_dup && !rsp_reject && !discard && !err_report,
              "R12 outputs low after reset", 0, 0);

        // R1, R3: fill the queue
        send(32'h100, 4'h6, r); check(r == ACC, "R1 accept A0", r, ACC);
        send(32'h100, 4'h7, r); check(r == ACC, "R3 same addr other cmd", r, ACC);
        send(32'h104, 4'h6, r); check(r == ACC, "R3 other addr same cmd", r, ACC);
        send(32'h108, 4'h6, r); check(r == ACC, "R1 accept fourth", r, ACC);
        // R2, R4: duplicates and rejects on a full queue
        for (int i = 0; i < 3; i++) begin
            send(32'h100 + 32'(4*i), 4'h6, r);
            check(r == DUP, "R2 R4 duplicate while full", r, DUP);
        end
        send(32'h100, 4'h7, r); check(r == DUP, "R2 duplicate cmd 7", r, DUP);
        send(32'h10c, 4'h6, r); check(r == REJ, "R4 reject when full", r, REJ);
        send(32'h100, 4'h5, r); check(r == REJ, "R4 reject partial match", r, REJ);

        // R5: retire oldest, reuse slot next cycle, FIFO order
        retire();
        send(32'h100, 4'h6, r); check(r == ACC, "R5 slot reused after retire", r, ACC);
        send(32'h100, 4'h7, r); check(r == DUP, "R5 second entry still queued", r, DUP);
        retire();
        send(32'h100, 4'h7, r); check(r == ACC, "R5 FIFO retire second", r, ACC);
        send(32'h104, 4'h6, r); check(r == DUP, "R5 third still queued", r, DUP);
        repeat (4) retire();
        // R11: repeat on empty queue is ignored; capacity intact
        retire();
        for (int i = 0; i < 4; i++) begin
            send(32'h200 + 32'(4*i), 4'h2, r);
            check(r == ACC, "R11 accept after empty repeat", r, ACC);
        end
        send(32'h300, 4'h2, r); check(r == REJ, "R11 capacity intact", r, REJ);
        repeat (4) retire();

        // R7, R8: sweep start values
        for (int t = 1; t <= 6; t++) begin
            tmo_value = 16'(t);
            err_en = t[0];
            send(32'h400, 4'hA, r);
            check(r == ACC, "R7 enqueue for timeout", r, ACC);
            cpl_ready = 1'b1; rdq_head = 1'b1;
            wait_discard(100, k, e);
            cpl_ready = 1'b0;
            check(k == t, "R7 expiry cycle", k, t);
            check(e == t[0], "R8 error follows enable", int'(e), t[0]);
            send(32'h400, 4'hA, r);
            check(r == ACC, "R7 entry removed", r, ACC);
            retire();
        end

        // R6: gate holds counter
        tmo_value = 16'd5; err_en = 1'b0;
        send(32'h500, 4'h1, r);
        cpl_ready = 1'b1; rdq_head = 1'b0;
        wait_discard(10, k, e);
        check(k == 10, "R6 no count without rdq_head", k, 10);
        cpl_ready = 1'b0; rdq_head = 1'b1;
        wait_discard(10, k, e);
        check(k == 10, "R6 no count without cpl_ready", k, 10);
        cpl_ready = 1'b1;
        wait_discard(2, k, e);
        check(k == 2, "R6 partial run", k, 2);
        rdq_head = 1'b0;
        wait_discard(4, k, e);
        check(k == 4, "R6 pause", k, 4);
        rdq_head = 1'b1;
        wait_discard(20, k, e);
        cpl_ready = 1'b0;
        check(k == 3, "R6 resumed count", k, 3);
        check(e == 1'b0, "R8 no error when disabled", int'(e), 0);

        // R9: reload for each new head
        tmo_value = 16'd4; err_en = 1'b1;
        send(32'h600, 4'h3, r);
        send(32'h604, 4'h3, r);
        send(32'h608, 4'h3, r);
        cpl_ready = 1'b1;
        for (int i = 0; i < 3; i++) begin
            wait_discard(20, k, e);
            check(k == 4, "R9 reload per head", k, 4);
        end
        wait_discard(10, k, e);
        check(k == 10, "R9 empty queue quiet", k, 10);
        cpl_ready = 1'b0;

        // R11: repeat beats expiry
        tmo_value = 16'd6;
        send(32'h700, 4'h4, r);
        send(32'h704, 4'h4, r);
        cpl_ready = 1'b1;
        wait_discard(5, k, e);
        check(k == 5 && !discard, "R11 no early expiry", k, 5);
        repeat_hit = 1'b1;
        @(negedge clk);
        repeat_hit = 1'b0;
        check(!discard, "R11 repeat wins over expiry", int'(discard), 0);
        wait_discard(20, k, e);
        cpl_ready = 1'b0;
        check(k == 6, "R11 R9 next head fresh count", k, 6);
        send(32'h700, 4'h4, r); check(r == ACC, "R11 retired entry gone", r, ACC);
        retire();

        // R10: zero selects default
        tmo_value = 16'd0;
        send(32'h800, 4'h5, r);
        cpl_ready = 1'b1;
        wait_discard(40000, k, e);
        cpl_ready = 1'b0;
        check(k == 32768, "R10 default timeout", k, 32768);

        finish_run();
    end
endmodule